// File: doc/BRIEF.md
# Synchronous Burst Static RAM Core

This block is a single-clock static RAM with four byte lanes and a small, parameterised depth. All inputs are registered on the rising edge. An access is a burst of up to four words. A burst opens from one of two start strobes. The first is a processor-side strobe, gated by the first chip enable and given priority. The second is a controller-side strobe that is not gated. Later words come from an internal 2-bit counter, which steps only when the advance input is asserted.

A mode input selects the burst order. In linear order the low two address bits count upward and wrap. In interleaved order the low two address bits are XORed with the count. Writes can target selected byte lanes through a byte-write enable, or all lanes at once through a global write. Reads are flow-through: the word addressed at an edge is presented after that same edge, with no added pipeline stage. A snooze input freezes the block while it is high.

Top module: `burst_sram`

## Requirements
- R1: A read cycle registered at an edge presents the addressed word on `dataOut` after that same edge, and raises `dataOutEn` when `outEnN` is low.
- R2: A processor start (`procStartN` low) while `chipEn1N` is high is ignored. Without a controller start, the cycle continues the current burst at its current address.
- R3: When both start strobes are low and `chipEn1N` is low, the processor start wins. It opens a read, and the write controls of that cycle are ignored.
- R4: A write opened by a processor start takes its write controls from the next cycle. With `advanceN` high in that cycle, it writes the burst's first address.
- R5: A controller start (`ctrlStartN` low) with write controls active writes the registered address in the start cycle itself.
- R6: The burst counter clears on every accepted start. It steps by one, modulo 4, only in continue cycles with `advanceN` low, and holds otherwise.
- R7: With `burstInterleave` low, the word address is the base address with its low two bits replaced by (base low bits + count) mod 4. From base 9 the order is 9, 10, 11, 8.
- R8: With `burstInterleave` high, the low two bits are the base low bits XOR the count. From base 9 the order is 9, 8, 11, 10.
- R9: With `byteWrEnN` low, each lane i whose `laneWrN[i]` is low stores `dataIn[8i+7:8i]`, and the other lanes keep their contents. With `byteWrEnN` high and `globalWrN` high, no lane is written.
- R10: `globalWrN` low writes all four lanes, whatever `byteWrEnN` and `laneWrN` are.
- R11: A start while any chip enable is inactive deselects the block: no write, and `dataOutEn` is low. Later continue cycles do nothing until a new accepted start.
- R12: `dataOutEn` is low while `outEnN` is high, after a write cycle, and while the block is deselected. `dataOut` is zero whenever `dataOutEn` is low.
- R13: While `snooze` is high, all other inputs are ignored, memory and burst state are kept, and `dataOutEn` is low.
- R14: After reset the block is deselected and `dataOutEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | Word address sampled on a burst start |
| dataIn | input | DATA_W | Write data, four byte lanes |
| procStartN | input | 1 | Processor-side burst start, active low, gated by chipEn1N |
| ctrlStartN | input | 1 | Controller-side burst start, active low, ungated |
| advanceN | input | 1 | Burst counter advance, active low |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneWrN | input | LANES | Per-lane write strobes, active low |
| burstInterleave | input | 1 | 0 linear order, 1 interleaved order |
| outEnN | input | 1 | Output enable, active low |
| snooze | input | 1 | Freeze the block while high |
| dataOut | output | DATA_W | Read word, zero when not driven |
| dataOutEn | output | 1 | High when dataOut carries valid read data |

## Verification
Two pairs of functions can fall in the same cycle. The first is both burst starts together with a global write. The bench asserts both strobes on one edge with a write pending and a distinct data word. It then judges, through a later read, that the processor start won and stored nothing in that cycle. The second pair is a burst start and snooze. A controller write start is issued while snooze is high. The bench then confirms that the older burst resumes at its address and that the targeted word is unchanged.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  parameter int LANES  = 4;
  parameter int LANE_W = 8;
  parameter int ADDR_W = 6;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [LANES-1:0]  laneWr;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } memStrobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStartN,
  input  logic              ctrlStartN,
  input  logic              advanceN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstInterleave,
  input  logic              outEnN,
  input  logic              snooze,
  output memStrobe_t        strobe,
  output logic              outDrive
);
  logic              selQ, selD;
  logic              rdQ, rdD;
  logic [ADDR_W-1:0] baseQ, baseD;
  logic [1:0]        cntQ, cntD;
  logic              procGo, startGo, chipOn, wantWr, doWr;
  logic [LANES-1:0]  laneReq;

  function automatic logic [ADDR_W-1:0] orderAddr(input logic [ADDR_W-1:0] base,
                                                  input logic [1:0] cnt,
                                                  input logic ilv);
    logic [1:0] low;
    low = ilv ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
    return {base[ADDR_W-1:2], low};
  endfunction

  always_comb begin
    procGo  = !procStartN && !chipEn1N;
    startGo = procGo || !ctrlStartN;
    chipOn  = !chipEn1N && chipEn2 && !chipEn3N;
    if (!globalWrN)      laneReq = '1;
    else if (!byteWrEnN) laneReq = ~laneWrN;
    else                 laneReq = '0;
    wantWr = |laneReq;

    selD  = selQ;
    rdD   = rdQ;
    baseD = baseQ;
    cntD  = cntQ;
    doWr  = 1'b0;
    if (!snooze) begin
      if (startGo) begin
        if (chipOn) begin
          selD  = 1'b1;
          baseD = addrIn;
          cntD  = 2'd0;
          doWr  = !procGo && wantWr;
          rdD   = procGo || !wantWr;
        end else begin
          selD = 1'b0;
          rdD  = 1'b0;
        end
      end else if (selQ) begin
        if (!advanceN) cntD = cntQ + 2'd1;
        doWr = wantWr;
        rdD  = !wantWr;
      end else begin
        rdD = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      rdQ   <= 1'b0;
      baseQ <= '0;
      cntQ  <= '0;
    end else begin
      selQ  <= selD;
      rdQ   <= rdD;
      baseQ <= baseD;
      cntQ  <= cntD;
    end
  end

  assign strobe.laneWr = doWr ? laneReq : '0;
  assign strobe.wrAddr = orderAddr(baseD, cntD, burstInterleave);
  assign strobe.rdAddr = orderAddr(baseQ, cntQ, burstInterleave);
  assign outDrive      = rdQ && selQ && !outEnN && !snooze;

  // R6
  start_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && startGo && chipOn) |=> (cntQ == 2'd0));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && !startGo && selQ && !advanceN) |=> (cntQ == $past(cntQ) + 2'd1));

  // R13
  snooze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    snooze |=> $stable({selQ, rdQ, baseQ, cntQ}));

  // R11
  deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && startGo && !chipOn) |=> !selQ);

  // R3
  proc_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && procGo) |-> (strobe.laneWr == '0));
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic              outDrive,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] rdWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.laneWr[g]) bank[strobe.wrAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = bank[strobe.rdAddr];

    // R9
    lane_store_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.laneWr[g] |=> (bank[$past(strobe.wrAddr)] == $past(dataIn[g*LANE_W +: LANE_W])));
  end

  assign dataOut = outDrive ? rdWord : '0;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              procStartN,
  input  logic              ctrlStartN,
  input  logic              advanceN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstInterleave,
  input  logic              outEnN,
  input  logic              snooze,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  memStrobe_t strobe;
  logic       outDrive;

  burst_sram_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStartN(procStartN), .ctrlStartN(ctrlStartN), .advanceN(advanceN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .burstInterleave(burstInterleave), .outEnN(outEnN), .snooze(snooze),
    .strobe(strobe), .outDrive(outDrive)
  );

  burst_sram_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .outDrive(outDrive),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  assign dataOutEn = outDrive;

  // R12
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> (!outEnN && !snooze));
endmodule

// File: tb/tb_burst_sram.sv
`timescale 1ns/100ps
module tb_burst_sram;
  import burst_sram_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn;
  logic [DATA_W-1:0] dataIn;
  logic procStartN, ctrlStartN, advanceN, chipEn1N, chipEn2, chipEn3N;
  logic globalWrN, byteWrEnN, burstInterleave, outEnN, snooze;
  logic [LANES-1:0]  laneWrN;
  logic [DATA_W-1:0] dataOut;
  logic              dataOutEn;

  typedef struct {
    logic        en;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t expQ[$];
  int nChecks = 0;
  int nErrors = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_sram dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .procStartN(procStartN), .ctrlStartN(ctrlStartN), .advanceN(advanceN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .burstInterleave(burstInterleave), .outEnN(outEnN), .snooze(snooze),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic [31:0] pat(input int a);
    return {8'(a + 160), 8'(a + 176), 8'(a + 192), 8'(a + 208)};
  endfunction

  task automatic idle();
    addrIn = '0; dataIn = '0;
    procStartN = 1'b1; ctrlStartN = 1'b1; advanceN = 1'b1;
    chipEn1N = 1'b0; chipEn2 = 1'b1; chipEn3N = 1'b0;
    globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = '1;
    burstInterleave = 1'b0; outEnN = 1'b0; snooze = 1'b0;
  endtask

  // Driver: queue the expectation for the edge ahead, then move to the next falling edge.
  task automatic step(input logic en, input logic [31:0] d, input string tag);
    exp_t e;
    e.en = en; e.data = d; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    idle();
  endtask

  // Monitor: compare just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      nChecks++;
      if (dataOutEn !== e.en || dataOut !== (e.en ? e.data : 32'h0)) begin
        nErrors++;
        $display("FAIL %s: got en=%0b data=%h, expected en=%0b data=%h",
                 e.tag, dataOutEn, dataOut, e.en, e.en ? e.data : 32'h0);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] p12;
    p12 = {pat(12)[31:8], 8'h44};
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R14 reset state
    step(1'b0, 32'h0, "R14");

    // R5: controller-start writes of words 8..15
    for (int a = 8; a < 16; a++) begin
      addrIn = ADDR_W'(a); ctrlStartN = 1'b0; globalWrN = 1'b0; dataIn = pat(a);
      step(1'b0, 32'h0, "R5 R12");
    end

    // R1 flow-through read via processor start
    addrIn = 6'd9; procStartN = 1'b0;
    step(1'b1, pat(9), "R1");
    // R7 linear order from base 9, R6 wrap and hold
    advanceN = 1'b0; step(1'b1, pat(10), "R7");
    advanceN = 1'b0; step(1'b1, pat(11), "R7");
    advanceN = 1'b0; step(1'b1, pat(8), "R7 R6");
    step(1'b1, pat(8), "R6 hold");
    advanceN = 1'b0; step(1'b1, pat(9), "R6 wrap");

    // R8 interleaved order from base 9
    burstInterleave = 1'b1; addrIn = 6'd9; ctrlStartN = 1'b0;
    step(1'b1, pat(9), "R8");
    burstInterleave = 1'b1; advanceN = 1'b0; step(1'b1, pat(8), "R8");
    burstInterleave = 1'b1; advanceN = 1'b0; step(1'b1, pat(11), "R8");
    burstInterleave = 1'b1; advanceN = 1'b0; step(1'b1, pat(10), "R8");
    // R12 output enable inactive
    burstInterleave = 1'b1; outEnN = 1'b1; step(1'b0, 32'h0, "R12");

    // R3 both starts with a global write: processor start wins, read only
    addrIn = 6'd12; procStartN = 1'b0; ctrlStartN = 1'b0; globalWrN = 1'b0;
    dataIn = 32'h0BAD0BAD;
    step(1'b1, pat(12), "R3");
    // R4 write controls from the following cycle, lane 0 only
    byteWrEnN = 1'b0; laneWrN = 4'b1110; dataIn = 32'h11223344;
    step(1'b0, 32'h0, "R4");
    addrIn = 6'd12; ctrlStartN = 1'b0;
    step(1'b1, p12, "R4 R9");

    // R10 global write overrides disabled byte writes
    addrIn = 6'd13; ctrlStartN = 1'b0; globalWrN = 1'b0; dataIn = 32'hCAFEF00D;
    step(1'b0, 32'h0, "R10");
    addrIn = 6'd13; ctrlStartN = 1'b0; step(1'b1, 32'hCAFEF00D, "R10");
    addrIn = 6'd14; ctrlStartN = 1'b0; globalWrN = 1'b0; byteWrEnN = 1'b0;
    laneWrN = 4'b0111; dataIn = 32'h5A5A5A5A;
    step(1'b0, 32'h0, "R10");
    addrIn = 6'd14; ctrlStartN = 1'b0; step(1'b1, 32'h5A5A5A5A, "R10");

    // R9 lanes 1 and 3; strobes without enable do not write
    addrIn = 6'd15; ctrlStartN = 1'b0; byteWrEnN = 1'b0; laneWrN = 4'b0101;
    dataIn = 32'hFFEEDDCC;
    step(1'b0, 32'h0, "R9");
    addrIn = 6'd15; ctrlStartN = 1'b0; laneWrN = 4'b0000; dataIn = 32'h0;
    step(1'b1, {8'hFF, pat(15)[23:16], 8'hDD, pat(15)[7:0]}, "R9");

    // R2 gated processor start ignored
    addrIn = 6'd10; ctrlStartN = 1'b0; step(1'b1, pat(10), "R1");
    addrIn = 6'd20; procStartN = 1'b0; chipEn1N = 1'b1;
    step(1'b1, pat(10), "R2");

    // R11 deselect
    addrIn = 6'd9; ctrlStartN = 1'b0; chipEn2 = 1'b0;
    step(1'b0, 32'h0, "R11");
    addrIn = 6'd9; ctrlStartN = 1'b0; chipEn3N = 1'b1; globalWrN = 1'b0;
    dataIn = 32'hDEADDEAD;
    step(1'b0, 32'h0, "R11");
    globalWrN = 1'b0; dataIn = 32'hDEADDEAD; step(1'b0, 32'h0, "R11");
    addrIn = 6'd9; ctrlStartN = 1'b0; step(1'b1, pat(9), "R11");

    // R13 snooze with a concurrent write start
    addrIn = 6'd11; ctrlStartN = 1'b0; step(1'b1, pat(11), "R1");
    snooze = 1'b1; addrIn = 6'd12; ctrlStartN = 1'b0; globalWrN = 1'b0;
    dataIn = 32'hBADBADBA;
    step(1'b0, 32'h0, "R13");
    step(1'b1, pat(11), "R13");
    addrIn = 6'd12; ctrlStartN = 1'b0; step(1'b1, p12, "R13");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule